// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block carries one card command from a register write to completion. A write presents a 32-bit argument and a command word. If the command word's enable bit is set, the block builds a 48-bit frame, shifts it out on the command line on successive launch strobes, and releases the line. It can then wait for the card's reply. The reply is either absent, a 48-bit short response with or without a CRC check, or a 136-bit long response. The reply lands in four 32-bit response words. The outcome is recorded in sticky status flags, which a write-one-to-clear port removes.

The surrounding controller supplies two single-cycle strobes derived from the card clock. `launch` marks where the host may change the line. `sample` marks where the card's line is read. One launch strobe counts as one card clock. The request port is valid/ready. `req_ready` is high only while the engine is idle, and a request is taken in the cycle where `req_valid` and `req_ready` are both high. A requester may hold `req_valid` with stable data for as long as the engine is busy; nothing is consumed until ready returns.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, all status bits and all response words are 0, `cmd_oe` is 0, `cmd_out` is 1 and `req_ready` is 1.
- R2: Requests are accepted only while idle. In `req_cmd`, bits 5:0 are the command index, bits 9:8 are the response kind, and bit 12 starts the engine. An accepted word with bit 12 clear is ignored: the engine stays idle and the line is not driven.
- R3: After a start, the next 48 launch strobes drive 0, 1, index[5:0], argument[31:0], CRC7, 1, most significant bit first. CRC7 uses x^7+x^3+1 with a zero seed over the first 40 bits. `cmd_oe` rises with the first bit. The launch strobe after the end bit releases the line (`cmd_oe` 0, `cmd_out` 1).
- R4: Status bit 13 reads 1 from the cycle after a start until the cycle after completion.
- R5: For response kind 00, the release of the line sets status bit 7 (command sent) and the engine returns to idle.
- R6: For any other kind, every sample strobe after the release tests `cmd_in`, and the first 0 seen is the response start bit.
- R7: If 64 sample strobes see `cmd_in` high, status bit 2 (timeout) is set, the engine goes idle and the response words keep their values.
- R8: For a short response (kinds 01 and 10), the 47 bits after the start bit are collected. Word 0 receives frame bits 39:8 and words 1 to 3 become 0.
- R9: For kind 01, CRC7 over frame bits 47:8 is compared with frame bits 7:1. A match sets bit 6 and a mismatch sets bit 0 instead. Kind 10 always sets bit 6.
- R10: For kind 11, the 135 bits after the start bit are collected. The words hold the last 128 bits received, with frame bit 127 at word 0 bit 31 and frame bit 96 at word 0 bit 0. Bit 6 is set and no CRC is checked.
- R11: While `clr_en` is high, each 1 in `clr_mask` clears the matching sticky flag. A flag set in the same cycle stays set. Flags with a 0 in the mask are untouched, and flags persist across commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_arg | input | 32 | Command argument |
| req_cmd | input | 16 | Command word: index 5:0, response kind 9:8, start 12 |
| clr_en | input | 1 | Apply clear mask this cycle |
| clr_mask | input | 16 | Write-one-to-clear mask for status flags |
| launch | input | 1 | Card-clock launch strobe |
| sample | input | 1 | Card-clock sample strobe |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| status | output | 16 | Flags: 0 CRC fail, 2 timeout, 6 response received, 7 sent, 13 busy |
| resp_w0 | output | 32 | Response word 0 |
| resp_w1 | output | 32 | Response word 1 |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |

## Verification
The assertions assume that `launch` and `sample` are single-cycle pulses that never coincide. They also assume that `cmd_in` moves only on launch strobes, so every sample strobe reads a settled level. The stimulus produces the strobes on a fixed four-cycle cadence: launch in phase 0 and sample in phase 2. The bench card model changes the line only in launch cycles, and requests are held valid until taken. Clear pulses are applied both between commands and across a completion cycle, to reach the case where a set and a clear collide.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int FRAME_W    = 48;
  localparam int STAT_W     = 16;
  localparam int F_CRCBAD   = 0;
  localparam int F_TMO      = 2;
  localparam int F_RSPOK    = 6;
  localparam int F_SENT     = 7;
  localparam int F_BUSY     = 13;
  localparam int CMD_EN_BIT = 12;
  localparam int KIND_LO    = 8;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'b00,
    RSP_SHORT_CRC = 2'b01,
    RSP_SHORT_RAW = 2'b10,
    RSP_LONG      = 2'b11
  } rsp_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RESP} eng_state_e;

  // CRC7, polynomial x^7 + x^3 + 1, zero seed, MSB first
  function automatic logic [6:0] crc7_40(input logic [39:0] bits);
    logic [6:0] r;
    logic fb;
    r = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ r[6];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'h09;
    end
    return r;
  endfunction
endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          launch,
  output logic          line_out,
  output logic          line_oe,
  output logic          fin
);
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          active;

  assign fin = active && launch && (cnt == CW'(FW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      line_out <= 1'b1;
      line_oe  <= 1'b0;
    end else if (load) begin
      sh     <= frame;
      cnt    <= '0;
      active <= 1'b1;
    end else if (active && launch) begin
      if (fin) begin
        active   <= 1'b0;
        line_oe  <= 1'b0;
        line_out <= 1'b1;
      end else begin
        line_oe  <= 1'b1;
        line_out <= sh[FW-1];
        sh       <= {sh[FW-2:0], 1'b0};
        cnt      <= cnt + 1'b1;
      end
    end
  end

  // R3: the first driven bit is the start bit
  p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out);
  // R3: the line is released high
  p_release_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> line_out);
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TMO_CLKS = 64,
  parameter int WORD_W   = 32,
  parameter int NWORDS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     long_rsp,
  input  logic                     sample,
  input  logic                     line_in,
  output logic                     fin,
  output logic                     tmo,
  output logic                     crc_ok,
  output logic [NWORDS*WORD_W-1:0] words
);
  localparam int KEEP    = NWORDS * WORD_W;
  localparam int SHORT_N = FRAME_W;
  localparam int LONG_N  = KEEP + 8;
  localparam int RCW     = $clog2(LONG_N);
  localparam int TCW     = $clog2(TMO_CLKS + 1);

  logic            waiting, receiving, long_q;
  logic [RCW-1:0]  rcnt, last;
  logic [TCW-1:0]  wcnt;
  logic [KEEP-1:0] sh, sh_nxt;

  assign sh_nxt = {sh[KEEP-2:0], line_in};
  assign last   = long_q ? RCW'(LONG_N - 2) : RCW'(SHORT_N - 2);
  assign fin    = receiving && sample && (rcnt == last);
  assign tmo    = waiting && sample && line_in && (wcnt == TCW'(TMO_CLKS - 1));
  assign crc_ok = (crc7_40({1'b0, sh_nxt[SHORT_N-2:8]}) == sh_nxt[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      receiving <= 1'b0;
      long_q    <= 1'b0;
      rcnt      <= '0;
      wcnt      <= '0;
      sh        <= '0;
      words     <= '0;
    end else if (arm) begin
      waiting   <= 1'b1;
      receiving <= 1'b0;
      wcnt      <= '0;
      long_q    <= long_rsp;
    end else if (waiting && sample) begin
      if (!line_in) begin
        waiting   <= 1'b0;
        receiving <= 1'b1;
        rcnt      <= '0;
      end else if (tmo) begin
        waiting <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (receiving && sample) begin
      sh   <= sh_nxt;
      rcnt <= rcnt + 1'b1;
      if (fin) begin
        receiving <= 1'b0;
        words <= long_q ? sh_nxt : {sh_nxt[39:8], {(KEEP-WORD_W){1'b0}}};
      end
    end
  end

  // R7: the wait counter never passes the timeout window
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (wcnt < TCW'(TMO_CLKS)));
  // R6: waiting for the start bit and collecting bits are exclusive
  p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(waiting && receiving));
  // R7: the words hold through a timeout
  p_words_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> $stable(words));
endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic         clr_en,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_v : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_eff) | set_v;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R11: a clear without a simultaneous set empties the flag
    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_v[i] && !set_v[i]) |=> !q[i]);
    // R11: a set wins over a clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> q[i]);
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TMO_CLKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_arg,
  input  logic [15:0] req_cmd,
  input  logic        clr_en,
  input  logic [15:0] clr_mask,
  input  logic        launch,
  input  logic        sample,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic [15:0] status,
  output logic [31:0] resp_w0,
  output logic [31:0] resp_w1,
  output logic [31:0] resp_w2,
  output logic [31:0] resp_w3
);
  eng_state_e       st;
  rsp_kind_e        kind_q;
  logic             go, tx_fin, rx_fin, rx_tmo, rx_crc_ok, arm;
  logic [FRAME_W-1:0] frame;
  logic [STAT_W-1:0]  set_v, flag_q;
  logic [127:0]       words;
  logic               unused_cmd_bits;

  assign unused_cmd_bits = ^{req_cmd[15:13], req_cmd[11:10], req_cmd[7:6]};
  assign req_ready = (st == ST_IDLE);
  assign go        = req_valid && req_ready && req_cmd[CMD_EN_BIT];
  assign frame     = {2'b01, req_cmd[5:0], req_arg,
                      crc7_40({2'b01, req_cmd[5:0], req_arg}), 1'b1};
  assign arm       = (st == ST_SEND) && tx_fin && (kind_q != RSP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind_q <= RSP_NONE;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st     <= ST_SEND;
          kind_q <= rsp_kind_e'(req_cmd[KIND_LO+1:KIND_LO]);
        end
        ST_SEND: if (tx_fin) st <= (kind_q == RSP_NONE) ? ST_IDLE : ST_RESP;
        ST_RESP: if (rx_fin || rx_tmo) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    set_v           = '0;
    set_v[F_SENT]   = (st == ST_SEND) && tx_fin && (kind_q == RSP_NONE);
    set_v[F_TMO]    = (st == ST_RESP) && rx_tmo;
    set_v[F_RSPOK]  = (st == ST_RESP) && rx_fin &&
                      ((kind_q != RSP_SHORT_CRC) || rx_crc_ok);
    set_v[F_CRCBAD] = (st == ST_RESP) && rx_fin &&
                      (kind_q == RSP_SHORT_CRC) && !rx_crc_ok;
  end

  sdcmd_tx #(.FW(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(go), .frame(frame), .launch(launch),
    .line_out(cmd_out), .line_oe(cmd_oe), .fin(tx_fin)
  );

  sdcmd_rx #(.TMO_CLKS(TMO_CLKS), .WORD_W(32), .NWORDS(4)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(arm), .long_rsp(kind_q == RSP_LONG),
    .sample(sample), .line_in(cmd_in), .fin(rx_fin), .tmo(rx_tmo),
    .crc_ok(rx_crc_ok), .words(words)
  );

  sdcmd_flags #(.W(STAT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_en(clr_en),
    .clr_v(clr_mask), .q(flag_q)
  );

  always_comb begin
    status         = flag_q;
    status[F_BUSY] = (st != ST_IDLE);
  end

  assign resp_w0 = words[127:96];
  assign resp_w1 = words[95:64];
  assign resp_w2 = words[63:32];
  assign resp_w3 = words[31:0];

  // R3: the line is driven only while a frame is being sent
  p_drive_in_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (st == ST_SEND));
  // R4: a start makes the engine busy on the next cycle
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> status[F_BUSY]);
  // R5 R9: a command ends with at most one outcome flag
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_v[F_SENT], set_v[F_TMO], set_v[F_RSPOK], set_v[F_CRCBAD]}));
  // R7: a timeout and a full response never coincide
  p_tmo_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_fin && rx_tmo));
endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, clr_en, launch, sample, cmd_in, cmd_out, cmd_oe;
  logic [31:0] req_arg, resp_w0, resp_w1, resp_w2, resp_w3;
  logic [15:0] req_cmd, clr_mask, status;

  sdcmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_arg(req_arg), .req_cmd(req_cmd), .clr_en(clr_en), .clr_mask(clr_mask),
    .launch(launch), .sample(sample), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .status(status), .resp_w0(resp_w0), .resp_w1(resp_w1),
    .resp_w2(resp_w2), .resp_w3(resp_w3)
  );

  int checks = 0, fails = 0, cyc = 0;
  // stimulus state
  logic rq_v = 1'b0; logic [31:0] rq_arg = '0; logic [15:0] rq_cmd = '0;
  logic cl_en = 1'b0, cl_hold = 1'b0; logic [15:0] cl_m = '0;
  logic card_line = 1'b1, card_on = 1'b0; int card_gap = 0; logic card_q[$];
  // reference model
  int m_st = 0, m_tc = 0, m_wc = 0, m_rc = 0; logic [1:0] m_rt = '0;
  logic [47:0] m_tx = '0; logic [135:0] m_rx = '0;
  logic e_oe = 1'b0, e_out = 1'b1; logic [15:0] e_flags = '0; logic [127:0] e_words = '0;

  function automatic logic [6:0] b_crc(input logic [39:0] v);
    logic [6:0] c; logic b;
    c = '0;
    for (int k = 0; k < 40; k++) begin
      b = v[39-k] ^ c[6];
      c = {c[5:0], b};
      c[3] = c[3] ^ b;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic model();
    logic [15:0] setv; logic [15:0] clr;
    setv = '0;
    clr = clr_en ? clr_mask : '0;
    case (m_st)
      0: if (req_valid && req_cmd[12]) begin
        m_tx = {2'b01, req_cmd[5:0], req_arg, b_crc({2'b01, req_cmd[5:0], req_arg}), 1'b1};
        m_rt = req_cmd[9:8]; m_st = 1; m_tc = 0;
      end
      1: if (launch) begin
        if (m_tc < 48) begin e_oe = 1'b1; e_out = m_tx[47-m_tc]; m_tc++; end
        else begin
          e_oe = 1'b0; e_out = 1'b1;
          if (m_rt == 2'b00) begin setv[7] = 1'b1; m_st = 0; end
          else begin m_st = 2; m_wc = 0; end
        end
      end
      2: if (sample) begin
        if (!cmd_in) begin m_st = 3; m_rc = 0; m_rx = '0; end
        else if (m_wc == 63) begin setv[2] = 1'b1; m_st = 0; end
        else m_wc++;
      end
      default: if (sample) begin
        m_rx = {m_rx[134:0], cmd_in}; m_rc++;
        if (m_rc == ((m_rt == 2'b11) ? 135 : 47)) begin
          m_st = 0;
          if (m_rt == 2'b11) begin e_words = m_rx[127:0]; setv[6] = 1'b1; end
          else begin
            e_words = {m_rx[39:8], 96'h0};
            if (m_rt == 2'b01 && b_crc({1'b0, m_rx[46:8]}) != m_rx[7:1]) setv[0] = 1'b1;
            else setv[6] = 1'b1;
          end
        end
      end
    endcase
    e_flags = (e_flags & ~clr) | setv;
  endtask

  task automatic step();
    logic acc;
    @(negedge clk);
    chk("R3 cmd_oe", {127'h0, cmd_oe}, {127'h0, e_oe});
    chk("R3 cmd_out", {127'h0, cmd_out}, {127'h0, e_out});
    chk("R2 req_ready", {127'h0, req_ready}, {127'h0, (m_st == 0)});
    chk("R4 busy", {127'h0, status[13]}, {127'h0, (m_st != 0)});
    chk("R11 flags", {112'h0, status & 16'hDFFF}, {112'h0, e_flags});
    chk("R8 words", {resp_w0, resp_w1, resp_w2, resp_w3}, e_words);
    cyc++;
    if (cyc > 150000) begin
      fails++; $display("FAIL watchdog expired"); finish_run();
    end
    launch = (cyc % 4 == 0);
    sample = (cyc % 4 == 2);
    if (launch && card_on && m_st >= 2) begin
      if (card_gap > 0) card_gap--;
      else if (card_q.size() > 0) card_line = card_q.pop_front();
      else card_line = 1'b1;
    end
    cmd_in = card_line;
    req_valid = rq_v; req_arg = rq_arg; req_cmd = rq_cmd;
    clr_en = cl_en; clr_mask = cl_m;
    acc = rq_v && (m_st == 0);
    model();
    if (acc) rq_v = 1'b0;
    if (!cl_hold) cl_en = 1'b0;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt, input logic en);
    rq_arg = arg; rq_cmd = {3'b000, en, 2'b00, rt, 2'b00, idx}; rq_v = 1'b1;
    while (rq_v) step();
    while (m_st != 0) step();
    repeat (6) step();
    card_on = 1'b0; card_line = 1'b1;
  endtask

  task automatic clear_all();
    cl_m = 16'hFFFF; cl_en = 1'b1; step(); repeat (2) step();
  endtask

  task automatic card_short(input logic [5:0] idx, input logic [31:0] body, input logic bad, input int gap);
    logic [47:0] f;
    f = {2'b00, idx, body, b_crc({2'b00, idx, body}) ^ {6'h0, bad}, 1'b1};
    card_q.delete();
    for (int k = 47; k >= 0; k--) card_q.push_back(f[k]);
    card_gap = gap; card_on = 1'b1;
  endtask

  task automatic card_long(input logic [127:0] body, input int gap);
    logic [135:0] f;
    f = {2'b00, 6'h3F, body};
    card_q.delete();
    for (int k = 135; k >= 0; k--) card_q.push_back(f[k]);
    card_gap = gap; card_on = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_arg = '0; req_cmd = '0; clr_en = 1'b0;
    clr_mask = '0; launch = 1'b0; sample = 1'b0; cmd_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", {112'h0, status}, 128'h0);
    chk("R1 reset line", {126'h0, cmd_oe, cmd_out}, 128'h1);
    rst_n = 1'b1;
    step();
    chk("R1 reset words", {resp_w0, resp_w1, resp_w2, resp_w3}, 128'h0);
    chk("R1 reset ready", {127'h0, req_ready}, 128'h1);

    // enable bit clear: ignored
    issue(6'd17, 32'h1234_5678, 2'b01, 1'b0);
    chk("R2 no start busy", {127'h0, status[13]}, 128'h0);
    chk("R2 no start drive", {127'h0, cmd_oe}, 128'h0);

    // no response expected
    issue(6'd0, 32'h0, 2'b00, 1'b1);
    chk("R5 sent flag", {127'h0, status[7]}, 128'h1);
    chk("R5 idle after send", {127'h0, status[13]}, 128'h0);
    clear_all();
    chk("R11 all cleared", {112'h0, status}, 128'h0);

    // short, CRC checked, good
    card_short(6'd17, 32'hCAFE_0900, 1'b0, 2);
    issue(6'd17, 32'h0000_0200, 2'b01, 1'b1);
    chk("R6 R8 good short ok flag", {127'h0, status[6]}, 128'h1);
    chk("R9 no crc fail", {127'h0, status[0]}, 128'h0);
    chk("R8 word0", {96'h0, resp_w0}, {96'h0, 32'hCAFE_0900});
    chk("R8 upper words zero", {32'h0, resp_w1, resp_w2, resp_w3}, 128'h0);

    // short, CRC checked, bad; clear of bit 2 leaves the others
    card_short(6'd13, 32'h0000_0E00, 1'b1, 0);
    issue(6'd13, 32'hFFFF_0000, 2'b01, 1'b1);
    chk("R9 crc fail flag", {127'h0, status[0]}, 128'h1);
    cl_m = 16'h0004; cl_en = 1'b1; step(); step();
    chk("R11 unrelated clear", {112'h0, status}, {112'h0, 16'h0041});
    clear_all();

    // short, CRC not checked, bad CRC still accepted
    card_short(6'd41, 32'h80FF_8000, 1'b1, 5);
    issue(6'd41, 32'h40FF_8000, 2'b10, 1'b1);
    chk("R9 raw short ok", {127'h0, status[6]}, 128'h1);
    chk("R9 raw short no fail", {127'h0, status[0]}, 128'h0);
    clear_all();

    // long response, clear of bit 6 held across completion
    cl_m = 16'h0040; cl_en = 1'b1; cl_hold = 1'b1;
    card_long(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211, 3);
    issue(6'd2, 32'h0, 2'b11, 1'b1);
    cl_hold = 1'b0; cl_en = 1'b0; step();
    chk("R10 long words", {resp_w0, resp_w1, resp_w2, resp_w3},
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211);
    chk("R11 held clear after set", {127'h0, status[6]}, 128'h0);
    card_long(128'hFFFF_0000_AAAA_5555_1234_0000_0000_0001, 0);
    issue(6'd9, 32'hABCD_0000, 2'b11, 1'b1);
    chk("R10 long ok flag", {127'h0, status[6]}, 128'h1);
    clear_all();

    // timeout: no start bit, words unchanged
    issue(6'd55, 32'h0, 2'b01, 1'b1);
    chk("R7 timeout flag", {127'h0, status[2]}, 128'h1);
    chk("R7 words kept", {resp_w0, resp_w1, resp_w2, resp_w3},
        128'hFFFF_0000_AAAA_5555_1234_0000_0000_0001);
    chk("R7 no response flag", {127'h0, status[6]}, 128'h0);

    // late start bit near the window edge
    card_short(6'd8, 32'h0000_01AA, 1'b0, 62);
    issue(6'd8, 32'h0000_01AA, 2'b01, 1'b1);
    repeat (4) step();
    finish_run();
  end
endmodule